// File: doc/BRIEF.md
# Run-Length Configuration Bitstream Expander

This block turns a byte-coded, run-length compressed configuration image into the serial bit stream that a slave-serial FPGA configuration port expects. Bytes arrive on a valid/ready stream. Bits leave one per cycle on a second valid/ready stream, which a separate stage converts into configuration clock and data edges.

The block first skips header bytes until it sees a sync pair: a byte of 0xFF followed by a byte whose upper nibble is 3. Both bytes of the pair are consumed and produce no output. Next it sends a fixed 16-bit lead-in. After that, every code byte expands into a run of identical bits, usually closed by one bit of the opposite value. The byte flagged as last ends the image. Once all of its bits have been taken, a done flag rises. The flag stays high until reset.

The longest run of ones is a parameter, `ONES_MAX`, with a default of 226. The two special code values are placed relative to it:

- `ONES_MAX+1` produces a run of ones with no closing bit.
- `ONES_MAX+2` is the base of the zero-run range.

Top module: `rle_bitstream_expander`

## Requirements
- R1: After reset, `inReady` is 1, `outValid` is 0 and `done` is 0.
- R2: Bytes are consumed without producing output until 0xFF is followed directly by a byte whose bits [7:4] equal 4'h3. Neither byte of that pair is decoded. A repeated 0xFF keeps the search armed, so FF FF 3x is recognised.
- R3: Once the sync pair is found, the first 16 output bits are 1,1,1,1,1,1,1,1,0,0,1,0,0,0,0,0. This is 0xFF then 0x20, most significant bit first.
- R4: A code byte n with 1 <= n <= ONES_MAX (226) produces n ones followed by one zero.
- R5: Code byte ONES_MAX+1 (227) produces ONES_MAX ones and no zero.
- R6: A code byte n with ONES_MAX+2 (228) <= n <= 254 produces n-228 zeros followed by one 1.
- R7: Code byte 255 produces exactly one 1.
- R8: Code byte 0 produces no output bits.
- R9: `inReady` is 0 in every cycle where `outValid` is 1. No byte is taken while the lead-in, a run or its closing bit is being sent.
- R10: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outBit` keeps its value on the next cycle.
- R11: `done` rises only after every bit of the byte flagged with `inLast` has been taken, and it then stays at 1. While `done` is 1, `outValid` and `inReady` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inByte | input | 8 | Compressed image byte |
| inValid | input | 1 | `inByte` is valid |
| inLast | input | 1 | Marks the final code byte of the image |
| inReady | output | 1 | Block accepts a byte this cycle |
| outBit | output | 1 | Expanded configuration bit |
| outValid | output | 1 | `outBit` is valid |
| outReady | input | 1 | Consumer takes `outBit` this cycle |
| done | output | 1 | Image fully expanded (sticky) |

## Verification
Two events can fall in the same cycle:

- the final bit of a run is taken while the output side is stalled, and
- the state of the last-byte flag decides between fetching the next code and finishing.

To provoke this, the bench applies periodic `outReady` stalls across runs that end with and without a closing bit. It also uses a zero code as the final byte, so that completion follows directly from a fetch.

Each stream is judged by comparing the collected bit sequence with one computed from the code rules. The bench also checks three further points:

- `done` appears only when the collected count equals the expected count;
- a held bit never changes under stall;
- no byte is accepted while bits are pending.

// File: rtl/rle_expander_pkg.sv
package rle_expander_pkg;

  typedef enum logic [2:0] {
    ST_SEEK_FF,
    ST_SEEK_SYNC,
    ST_LEAD,
    ST_FETCH,
    ST_RUN,
    ST_TERM,
    ST_DONE
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic clearLead;
    logic stepLead;
    logic loadCode;
    logic decRun;
    logic emitLead;
    logic emitTerm;
  } ctrlT;

  // status from datapath to control
  typedef struct packed {
    logic byteIsFF;
    logic byteIsSync;
    logic codeSkip;
    logic codeTermOnly;
    logic leadLast;
    logic runLast;
    logic runHasTerm;
    logic lastSeen;
  } statT;

endpackage

// File: rtl/rle_expander_dp.sv
module rle_expander_dp
  import rle_expander_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ONES_MAX = 226,
  parameter int LEAD_LEN = 16,
  parameter logic [LEAD_LEN-1:0] LEAD_WORD = 16'hFF20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] inByte,
  input  logic              inLast,
  input  ctrlT              ctrl,
  output statT              sts,
  output logic              outBit
);

  localparam int CNT_W  = DATA_W;
  localparam int LIDX_W = $clog2(LEAD_LEN);
  localparam logic [DATA_W-1:0] K_ONESMAX = DATA_W'(ONES_MAX);
  localparam logic [DATA_W-1:0] K_NOTERM  = DATA_W'(ONES_MAX + 1);
  localparam logic [DATA_W-1:0] K_ZBASE   = DATA_W'(ONES_MAX + 2);
  localparam logic [DATA_W-1:0] K_ALLONE  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] K_FF      = {DATA_W{1'b1}};

  logic [CNT_W-1:0]  runCnt, nxtCnt;
  logic              runBit, nxtBit;
  logic              hasTerm, nxtTerm;
  logic              lastSeen;
  logic [LIDX_W-1:0] leadIdx;
  logic              leadBit;

  // code byte classification
  always_comb begin
    nxtCnt  = '0;
    nxtBit  = 1'b0;
    nxtTerm = 1'b1;
    if (inByte == K_ALLONE) begin
      nxtCnt = '0;
      nxtBit = 1'b0;
    end else if (inByte >= K_ZBASE) begin
      nxtCnt = inByte - K_ZBASE;
      nxtBit = 1'b0;
    end else if (inByte == K_NOTERM) begin
      nxtCnt  = K_ONESMAX;
      nxtBit  = 1'b1;
      nxtTerm = 1'b0;
    end else begin
      nxtCnt = inByte;
      nxtBit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runCnt   <= '0;
      runBit   <= 1'b0;
      hasTerm  <= 1'b0;
      lastSeen <= 1'b0;
    end else if (ctrl.loadCode) begin
      runCnt   <= nxtCnt;
      runBit   <= nxtBit;
      hasTerm  <= nxtTerm;
      lastSeen <= inLast;
    end else if (ctrl.decRun) begin
      runCnt <= runCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              leadIdx <= '0;
    else if (ctrl.clearLead) leadIdx <= '0;
    else if (ctrl.stepLead)  leadIdx <= leadIdx + LIDX_W'(1);
  end

  assign leadBit = LEAD_WORD[LIDX_W'(LEAD_LEN - 1) - leadIdx];
  assign outBit  = ctrl.emitLead ? leadBit : (ctrl.emitTerm ? ~runBit : runBit);

  assign sts.byteIsFF     = (inByte == K_FF);
  assign sts.byteIsSync   = (inByte[DATA_W-1 -: 4] == 4'h3);
  assign sts.codeSkip     = (inByte == '0);
  assign sts.codeTermOnly = nxtTerm && (nxtCnt == '0);
  assign sts.leadLast     = (leadIdx == LIDX_W'(LEAD_LEN - 1));
  assign sts.runLast      = (runCnt == CNT_W'(1));
  assign sts.runHasTerm   = hasTerm;
  assign sts.lastSeen     = lastSeen;

  // a run is never stepped past empty
  assert_run_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.decRun |-> runCnt != '0);

  // a run never exceeds the longest ones run
  assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    runCnt <= K_ONESMAX);

endmodule

// File: rtl/rle_expander_ctl.sv
module rle_expander_ctl
  import rle_expander_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inValid,
  input  logic inLast,
  input  logic outReady,
  input  statT sts,
  output ctrlT ctrl,
  output logic inReady,
  output logic outValid,
  output logic done
);

  stateT state, nextState;
  logic  accept, fire;

  assign inReady  = (state == ST_SEEK_FF) || (state == ST_SEEK_SYNC) || (state == ST_FETCH);
  assign outValid = (state == ST_LEAD) || (state == ST_RUN) || (state == ST_TERM);
  assign done     = (state == ST_DONE);
  assign accept   = inValid && inReady;
  assign fire     = outValid && outReady;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_SEEK_FF:
        if (accept && sts.byteIsFF) nextState = ST_SEEK_SYNC;
      ST_SEEK_SYNC:
        if (accept) begin
          if (sts.byteIsSync)     nextState = ST_LEAD;
          else if (!sts.byteIsFF) nextState = ST_SEEK_FF;
        end
      ST_LEAD:
        if (fire && sts.leadLast) nextState = ST_FETCH;
      ST_FETCH:
        if (accept) begin
          if (sts.codeSkip)          nextState = inLast ? ST_DONE : ST_FETCH;
          else if (sts.codeTermOnly) nextState = ST_TERM;
          else                       nextState = ST_RUN;
        end
      ST_RUN:
        if (fire && sts.runLast) begin
          if (sts.runHasTerm)    nextState = ST_TERM;
          else if (sts.lastSeen) nextState = ST_DONE;
          else                   nextState = ST_FETCH;
        end
      ST_TERM:
        if (fire) nextState = sts.lastSeen ? ST_DONE : ST_FETCH;
      ST_DONE:
        nextState = ST_DONE;
      default:
        nextState = ST_SEEK_FF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_SEEK_FF;
    else        state <= nextState;
  end

  always_comb begin
    ctrl.clearLead = (state == ST_SEEK_SYNC) && accept && sts.byteIsSync;
    ctrl.stepLead  = (state == ST_LEAD) && fire;
    ctrl.loadCode  = (state == ST_FETCH) && accept;
    ctrl.decRun    = (state == ST_RUN) && fire;
    ctrl.emitLead  = (state == ST_LEAD);
    ctrl.emitTerm  = (state == ST_TERM);
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(ctrl.emitTerm) && $stable(ctrl.emitLead)));

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_load_emits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.loadCode && !sts.codeSkip) |=> outValid);

endmodule

// File: rtl/rle_bitstream_expander.sv
module rle_bitstream_expander
  import rle_expander_pkg::*;
#(
  parameter int ONES_MAX = 226
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] inByte,
  input  logic       inValid,
  input  logic       inLast,
  output logic       inReady,
  output logic       outBit,
  output logic       outValid,
  input  logic       outReady,
  output logic       done
);

  ctrlT ctrl;
  statT sts;

  rle_expander_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inLast(inLast),
    .outReady(outReady), .sts(sts), .ctrl(ctrl),
    .inReady(inReady), .outValid(outValid), .done(done)
  );

  rle_expander_dp #(.DATA_W(8), .ONES_MAX(ONES_MAX), .LEAD_LEN(16), .LEAD_WORD(16'hFF20)) u_dp (
    .clk(clk), .rst_n(rst_n), .inByte(inByte), .inLast(inLast),
    .ctrl(ctrl), .sts(sts), .outBit(outBit)
  );

  assert_held_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> $stable(outBit));

  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!outValid && !inReady));

endmodule

// File: tb/rle_bitstream_expander_bench.sv
module rle_bitstream_expander_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] inByte = '0;
  logic       inValid = 1'b0, inLast = 1'b0, outReady = 1'b0;
  logic       inReady, outBit, outValid, done;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  rle_bitstream_expander u_rle_bitstream_expander (
    .clk(clk), .rst_n(rst_n), .inByte(inByte), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .outBit(outBit), .outValid(outValid), .outReady(outReady), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void expandCode(input int b, ref bit q[$]);
    if (b >= 1 && b <= 226) begin
      for (int i = 0; i < b; i++) q.push_back(1'b1);
      q.push_back(1'b0);
    end else if (b == 227) begin
      for (int i = 0; i < 226; i++) q.push_back(1'b1);
    end else if (b >= 228 && b <= 254) begin
      for (int i = 0; i < b - 228; i++) q.push_back(1'b0);
      q.push_back(1'b1);
    end else if (b == 255) begin
      q.push_back(1'b1);
    end
  endfunction

  task automatic doReset();
    rst_n = 1'b0; inValid = 1'b0; inLast = 1'b0; inByte = '0; outReady = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic runStream(input logic [7:0] arr[$], input int payStart, input bit stall, input string req);
    bit exp[$];
    bit got[$];
    logic [15:0] lead = 16'hFF20;
    int idx = 0, cycles = 0, busyAccept = 0, holdErr = 0, firstBad = -1;
    bit haveHold = 0, heldBit = 0;
    for (int i = 15; i >= 0; i--) exp.push_back(lead[i]);
    for (int i = payStart; i < arr.size(); i++) expandCode(int'(arr[i]), exp);
    doReset();
    while (!done && cycles < 20000) begin
      @(negedge clk);
      cycles++;
      if (haveHold && !(outValid && outBit == heldBit)) holdErr++;
      inValid  = (idx < arr.size());
      inByte   = inValid ? arr[idx] : 8'h00;
      inLast   = inValid && (idx == arr.size() - 1);
      outReady = stall ? ((cycles % 3) != 0) : 1'b1;
      #1;
      if (outValid && inReady) busyAccept++;
      if (inValid && inReady) idx++;
      haveHold = outValid && !outReady;
      heldBit  = outBit;
      if (outValid && outReady) got.push_back(outBit);
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    for (int i = 0; i < got.size() && i < exp.size(); i++)
      if (got[i] != exp[i] && firstBad < 0) firstBad = i;
    check(done == 1'b1, "R11", "done after last byte", int'(done), 1);
    check(got.size() == exp.size(), "R11", "bits taken before done", got.size(), exp.size());
    check(firstBad < 16 ? firstBad < 0 : 1'b1, "R3", "lead-in first mismatching bit", firstBad, -1);
    check(firstBad < 0, req, "first mismatching bit", firstBad, -1);
    check(idx == arr.size(), "R2", "bytes consumed", idx, arr.size());
    check(busyAccept == 0, "R9", "ready while emitting", busyAccept, 0);
    if (stall) check(holdErr == 0, "R10", "held bit changed", holdErr, 0);
    @(negedge clk);
    check(!outValid && !inReady && done, "R11", "quiet after done",
          int'({done, inReady, outValid}), 4);
  endtask

  task automatic testReset();
    doReset();
    #1;
    check(inReady == 1'b1, "R1", "inReady after reset", int'(inReady), 1);
    check(outValid == 1'b0, "R1", "outValid after reset", int'(outValid), 0);
    check(done == 1'b0, "R1", "done after reset", int'(done), 0);
  endtask

  task automatic testOnesRuns();
    logic [7:0] s[$] = '{8'h00, 8'h12, 8'hFF, 8'h41, 8'hFF, 8'h35, 8'd3, 8'd226, 8'd1};
    runStream(s, 6, 1'b0, "R4");
  endtask

  task automatic testNoTerm();
    logic [7:0] s[$] = '{8'hFF, 8'h3A, 8'd227, 8'd227};
    runStream(s, 2, 1'b0, "R5");
  endtask

  task automatic testZeroRuns();
    logic [7:0] s[$] = '{8'hFF, 8'h30, 8'd228, 8'd254, 8'd229};
    runStream(s, 2, 1'b0, "R6");
  endtask

  task automatic testSingleOne();
    logic [7:0] s[$] = '{8'hFF, 8'h31, 8'd0, 8'd255, 8'd0, 8'd255, 8'd0};
    runStream(s, 2, 1'b0, "R7");
  endtask

  task automatic testSkipOnly();
    logic [7:0] s[$] = '{8'hFF, 8'h30, 8'd0, 8'd0};
    runStream(s, 2, 1'b0, "R8");
  endtask

  task automatic testStall();
    logic [7:0] s[$] = '{8'hFF, 8'h3F, 8'd5, 8'd229, 8'd227, 8'd2, 8'd255};
    runStream(s, 2, 1'b1, "R10");
  endtask

  task automatic testSyncSearch();
    logic [7:0] s[$] = '{8'hFF, 8'h20, 8'hFF, 8'hFF, 8'h30, 8'd2, 8'd230};
    runStream(s, 5, 1'b1, "R2");
  endtask

  initial begin
    #(20 * 150000);
    testsRun++;
    testsFailed++;
    $display("FAIL R11 watchdog expired: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    testReset();
    testOnesRuns();
    testNoTerm();
    testZeroRuns();
    testSingleOne();
    testSkipOnly();
    testStall();
    testSyncSearch();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule